// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns one presented address into the addresses of a four-beat burst. When the step/load control is low, the sequencer captures the external address. That address is the first beat. Each later cycle with the control high moves the two low address bits on to the next beat. The upper bits are left as they were.

The step order is chosen when the burst is loaded. Linear order counts the low bits upward modulo four and wraps inside the aligned group of four words. Interleaved order XORs the starting low bits with a beat count that runs 0, 1, 2, 3. A suspend input freezes the whole sequencer. The sequencer is meant to sit in front of a synchronous memory array that serves several data beats for a single address cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset forces `addr_out` to all zeros from the first clock edge at which it is sampled high.
- R2: A clock edge with `suspend`=0 and `step`=0 loads `addr_in`, and `addr_out` equals that address right after the edge.
- R3: With `order_sel`=0 captured at load (linear), each step edge makes the low two bits of `addr_out` equal the previous low bits plus one, modulo 4.
- R4: With `order_sel`=1 captured at load (interleaved), the low two bits after the k-th step (k = 0..3, taken modulo 4) equal the loaded low bits XOR k.
- R5: `order_sel` is sampled only on load edges. Changing it during step edges has no effect on the sequence.
- R6: Four step edges after a load bring `addr_out` back to the loaded address, in both orders.
- R7: Bits `ADDR_W-1:2` of `addr_out` change only on load edges or on reset, never on step edges.
- R8: While `suspend`=1 the sequencer neither loads nor steps, and `addr_out` keeps its value whatever `step`, `order_sel` and `addr_in` do.
- R9: The order can differ from one burst to the next, so a linear burst followed by an interleaved burst (and the reverse) each follow their own order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| suspend | input | 1 | 1 freezes all state |
| step | input | 1 | 1 steps to the next beat, 0 loads `addr_in` |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order (sampled at load) |
| addr_in | input | ADDR_W | External address to load |
| addr_out | output | ADDR_W | Current burst address |

## Verification
All state sits in registers and `addr_out` is decoded from those registers by combinational logic alone. Every load, step, suspend or reset therefore shows up at `addr_out` one edge after the cycle in which it was presented. The bench drives its inputs on the falling edge and updates its own model at the rising edge. It compares `addr_out` two nanoseconds after that rising edge, once the new register values have settled and well before the next drive. Suspended cycles are checked the same way, one edge later, against an unchanged expected value.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        beat_t  start;
        order_e mode;
    } burst_cfg_t;

    function automatic beat_t low_bits(beat_t start, beat_t beat, order_e mode);
        beat_t r;
        if (mode == ORD_INTERLEAVE) r = start ^ beat;
        else                        r = start + beat;
        return r;
    endfunction
endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
    import bsq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  do_load,
    input  logic  do_step,
    output beat_t beat_o
);
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst)          beat_q <= '0;
        else if (do_load) beat_q <= '0;
        else if (do_step) beat_q <= beat_q + 1'b1;
    end

    assign beat_o = beat_q;

    // R6: the count restarts at zero on every load
    p_beat_restart_r6: assert property (@(posedge clk) disable iff (rst)
        do_load |=> beat_o == '0);
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int UP_W = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              do_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_in,
    output logic [UP_W-1:0]   upper_o,
    output burst_cfg_t        cfg_o
);
    logic [UP_W-1:0] upper_q;
    burst_cfg_t      cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            cfg_q   <= '{start: '0, mode: ORD_LINEAR};
        end else if (do_load) begin
            upper_q <= addr_in[ADDR_W-1:BEAT_W];
            cfg_q   <= '{start: addr_in[BEAT_W-1:0], mode: order_e'(order_in)};
        end
    end

    assign upper_o = upper_q;
    assign cfg_o   = cfg_q;

    // R5 and R7: without a load the captured fields hold
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !do_load |=> $stable(cfg_o) && $stable(upper_o));
endmodule

// File: rtl/bsq_low_map.sv
module bsq_low_map
    import bsq_pkg::*;
(
    input  burst_cfg_t cfg,
    input  beat_t      beat,
    output beat_t      low_o
);
    assign low_o = low_bits(cfg.start, beat, cfg.mode);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              suspend,
    input  logic              step,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - BEAT_W;

    logic            do_load;
    logic            do_step;
    beat_t           beat;
    beat_t           low;
    burst_cfg_t      cfg;
    logic [UP_W-1:0] upper;

    assign do_load = !suspend && !step;
    assign do_step = !suspend &&  step;

    bsq_beat_ctr u_beat (
        .clk     (clk),
        .rst     (rst),
        .do_load (do_load),
        .do_step (do_step),
        .beat_o  (beat)
    );

    bsq_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .do_load  (do_load),
        .addr_in  (addr_in),
        .order_in (order_sel),
        .upper_o  (upper),
        .cfg_o    (cfg)
    );

    bsq_low_map u_map (
        .cfg   (cfg),
        .beat  (beat),
        .low_o (low)
    );

    assign addr_out = {upper, low};

    // R2
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        !suspend && !step |=> addr_out == $past(addr_in));

    // R8
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        suspend |=> $stable(addr_out));

    // R7
    p_upper_r7: assert property (@(posedge clk) disable iff (rst)
        !suspend && step |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R3
    p_linear_r3: assert property (@(posedge clk) disable iff (rst)
        !suspend && step && cfg.mode == ORD_LINEAR
        |=> addr_out[BEAT_W-1:0] == beat_t'($past(addr_out[BEAT_W-1:0]) + 1'b1));

    // R4: an interleaved step flips at least one low bit
    p_ilv_r4: assert property (@(posedge clk) disable iff (rst)
        !suspend && step && cfg.mode == ORD_INTERLEAVE
        |=> $countones(addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) != 0);
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst;
    logic              suspend;
    logic              step;
    logic              order_sel;
    logic [ADDR_W-1:0] addr_in;
    logic [ADDR_W-1:0] addr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model
    logic [ADDR_W-1:0] m_base;
    logic [1:0]        m_beat;
    logic              m_ilv;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .suspend   (suspend),
        .step      (step),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out)
    );

    function automatic logic [ADDR_W-1:0] expect_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[ADDR_W-1:2], lo};
    endfunction

    task automatic check(string req, logic [ADDR_W-1:0] exp);
        n_checks++;
        if (addr_out !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // one cycle: drive at falling edge, update model at rising edge, sample 2 ns later
    task automatic cyc(logic s, logic st, logic o, logic [ADDR_W-1:0] a, string req);
        @(negedge clk);
        suspend = s; step = st; order_sel = o; addr_in = a;
        @(posedge clk);
        if (!s) begin
            if (!st) begin m_base = a; m_beat = 2'd0; m_ilv = o; end
            else m_beat = m_beat + 2'd1;
        end
        #2;
        check(req, expect_addr());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        int seed;
        logic [ADDR_W-1:0] a0;
        seed = 17;
        void'($urandom(seed));
        rst = 1; suspend = 0; step = 0; order_sel = 0; addr_in = '1;
        m_base = '0; m_beat = 0; m_ilv = 0;
        @(posedge clk); @(posedge clk); #2;
        check("R1 reset", '0);
        @(negedge clk); rst = 0; step = 1; addr_in = '0;
        @(posedge clk); m_beat = m_beat + 2'd1; #2;
        check("R1 step after reset", expect_addr());

        // linear burst from low bits 2: 2,3,0,1 then back to 2
        a0 = 18'h2A56E;
        cyc(0, 0, 0, a0, "R2 load linear");
        check("R2 loaded value", a0);
        cyc(0, 1, 1, '1, "R3 linear beat1");
        check("R3 low bits 3", {a0[ADDR_W-1:2], 2'd3});
        cyc(0, 1, 1, '0, "R5 order change ignored");
        check("R7 upper held wrap", {a0[ADDR_W-1:2], 2'd0});
        cyc(0, 1, 0, '0, "R3 linear beat3");
        cyc(0, 1, 0, '0, "R6 linear wrap");
        check("R6 back to loaded", a0);

        // interleaved burst from low bits 1: 1,0,3,2 then 1
        a0 = 18'h15551;
        cyc(0, 0, 1, a0, "R9 switch to interleaved");
        cyc(0, 1, 0, '1, "R4 ilv beat1");
        check("R4 low bits 0", {a0[ADDR_W-1:2], 2'd0});
        cyc(0, 1, 0, '1, "R4 ilv beat2");
        check("R4 low bits 3", {a0[ADDR_W-1:2], 2'd3});
        cyc(1, 0, 0, 18'h00000, "R8 suspend ignores load");
        check("R8 held", {a0[ADDR_W-1:2], 2'd3});
        cyc(1, 1, 1, 18'h3FFFF, "R8 suspend ignores step");
        cyc(0, 1, 0, '0, "R4 ilv beat3");
        check("R4 low bits 2", {a0[ADDR_W-1:2], 2'd2});
        cyc(0, 1, 0, '0, "R6 ilv wrap");
        check("R6 ilv back to loaded", a0);
        cyc(0, 0, 0, 18'h00003, "R9 back to linear");
        cyc(0, 1, 1, '0, "R9 linear wraps group");
        check("R9 low bits 0", 18'h00000);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [ADDR_W-1:0] ra;
            ra = ADDR_W'($urandom);
            cyc(($urandom % 5) == 0, ($urandom % 4) != 0, $urandom % 2, ra, "R2 R3 R4 R8 random");
        end

        @(negedge clk); rst = 1;
        @(posedge clk); m_base = '0; m_beat = 0; m_ilv = 0; #2;
        check("R1 reset mid-burst", '0);
        finish_run();
    end
endmodule